// File: doc/BRIEF.md
# Quadrature Sine/Cosine Synthesizer

This block generates a pair of local-oscillator samples, sine and cosine, for use in a complex down-conversion mixer. A wide phase accumulator advances by a programmable frequency word on every enabled clock. The upper bits of the accumulator form a 1024-point phase index, and the lower bits are discarded.

Only one quarter of a sine period is stored, as 256 unsigned magnitudes. For each output, folding logic maps the full-cycle index onto that quarter. The folding mirrors the table address and negates the result as the quadrant requires. The cosine lane uses the same index advanced by a quarter cycle. The two lanes read the one table through two read ports in the same cycle, so both samples leave together, tagged by a valid strobe.

The stored points sit at half-step angles. As a result, the mirror and negate operations are exact, and no full-cycle entry needs special handling.

Top module: `quad_lo_synth`

## Requirements
- R1: While `rst_n` is low and on the first edge after its release, `valid_o` is 0 and `sin_o` and `cos_o` are 0. The accumulator restarts at 0, so the first enabled sample uses index 0.
- R2: Each clock edge that samples `en_i` high adds `freq_i` to the 28-bit accumulator, modulo 2^28. A word near 2^28 therefore steps the phase backwards.
- R3: The phase index is the top 10 bits of the accumulator, taken by truncation without rounding. Accumulator bits 17..0 never change an output sample.
- R4: With p being the index of the accumulator before the add, `sin_o` = round(2047·sin(2π(p+0.5)/1024)) as a signed 12-bit value, with ties rounded away from zero. Its magnitude never exceeds 2047.
- R5: In the same cycle as R4, `cos_o` = round(2047·cos(2π(p+0.5)/1024)). This value equals the sine lane evaluated at index p+256 mod 1024.
- R6: The sample for an enabled edge appears at the outputs right after that edge, which is a latency of one clock. On that edge `valid_o` becomes 1. After an edge with `en_i` low, `valid_o` is 0.
- R7: An edge with `en_i` low leaves the accumulator, `sin_o` and `cos_o` unchanged.
- R8: Quadrant folding works as follows. Index bit 8 (the lower quadrant bit) mirrors the table address. Index bit 9 (the upper quadrant bit) negates the magnitude. Hence sin(p+512) = −sin(p) and sin(511−p) = sin(p) for every p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Advance phase and produce a sample |
| freq_i | input | 28 | Phase increment per enabled clock |
| sin_o | output | 12 | Signed sine sample |
| cos_o | output | 12 | Signed cosine sample |
| valid_o | output | 1 | Sample produced on the last edge |

## Verification
The bench builds the block with its default widths: a 28-bit accumulator, a 10-bit index and 12-bit samples. With these values, an increment of 2^18 visits every one of the 1024 indexes in 1024 clocks. That sweep reaches each table entry from both mirrored and negated quadrants, including the cells on both sides of each quadrant seam. The bench also runs the following cases:
- a half-step increment, which tests truncation;
- an increment of 2^28 − 2^18, which runs the phase backwards through the modulo wrap;
- sequences with enable gaps, which test the hold behaviour.

// File: rtl/qlo_pkg.sv
// Package: shared widths and the table-value function of the quadrature
// synthesizer. Assumes the amplitude fits in AMP_W-1 unsigned bits.
package qlo_pkg;

    localparam int unsigned ACC_W_DEF = 28;
    localparam int unsigned PH_W_DEF  = 10;
    localparam int unsigned AMP_W_DEF = 12;

    localparam real TWO_PI = 6.283185307179586;

    // Magnitude of one quarter-cycle entry at a half-step angle
    function automatic int unsigned quarter_mag(int unsigned k, int unsigned full_pts,
                                                int unsigned peak);
        real ang;
        ang = TWO_PI * (real'(k) + 0.5) / real'(full_pts);
        return int'($rtoi(real'(peak) * $sin(ang) + 0.5));
    endfunction

endpackage

// File: rtl/qlo_phase_acc.sv
// Phase accumulator: adds the frequency word on every enabled edge and
// wraps modulo 2^ACC_W. Synchronous active-low reset to zero.
module qlo_phase_acc #(
    parameter int unsigned ACC_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [ACC_W-1:0] freq_i,
    output logic [ACC_W-1:0] acc_o
);
    logic [ACC_W-1:0] acc_q;

    // Advance the phase by the frequency word when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (en_i) acc_q <= acc_q + freq_i;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/qlo_fold.sv
// Quadrant folding: maps a full-cycle index to a quarter-table address
// and a negate flag. Lower quadrant bit mirrors, upper quadrant bit negates.
// Assumes the table stores half-step samples so mirroring is exact.
module qlo_fold #(
    parameter int unsigned PH_W = 10
) (
    input  logic [PH_W-1:0] phase_i,
    output logic [PH_W-3:0] addr_o,
    output logic            neg_o
);
    localparam int unsigned QA_W = PH_W - 2;

    logic [QA_W-1:0] offs;

    // Pick address and sign from the quadrant bits
    always_comb begin
        offs   = phase_i[QA_W-1:0];
        addr_o = phase_i[PH_W-2] ? ~offs : offs;
        neg_o  = phase_i[PH_W-1];
    end
endmodule

// File: rtl/qlo_quarter_rom.sv
// Quarter-wave magnitude table with LANES registered read ports.
// Contents are computed at start-up from the package function; reads
// update only when enabled, otherwise the outputs hold.
module qlo_quarter_rom #(
    parameter int unsigned PH_W  = 10,
    parameter int unsigned AMP_W = 12,
    parameter int unsigned LANES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en_i,
    input  logic [LANES-1:0][PH_W-3:0]    addr_i,
    output logic [LANES-1:0][AMP_W-2:0]   mag_o
);
    import qlo_pkg::*;

    localparam int unsigned QA_W   = PH_W - 2;
    localparam int unsigned QN     = 1 << QA_W;
    localparam int unsigned FULL_N = 1 << PH_W;
    localparam int unsigned MAG_W  = AMP_W - 1;
    localparam int unsigned PEAK   = (1 << MAG_W) - 1;

    logic [MAG_W-1:0] tbl [QN];

    // Fill the quarter table with rounded half-step sine magnitudes
    initial begin
        for (int k = 0; k < QN; k++)
            tbl[k] = MAG_W'(quarter_mag(k, FULL_N, PEAK));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_port
        // Registered read of one port
        always_ff @(posedge clk) begin
            if (!rst_n)       mag_o[g] <= '0;
            else if (rd_en_i) mag_o[g] <= tbl[addr_i[g]];
        end
    end
endmodule

// File: rtl/quad_lo_synth.sv
// Quadrature synthesizer top: accumulator, two folding lanes (sine and
// quarter-advanced cosine), shared dual-read quarter table, sign restore.
// One clock from an enabled edge to the sample; valid marks that edge.
module quad_lo_synth #(
    parameter int unsigned ACC_W = 28,
    parameter int unsigned PH_W  = 10,
    parameter int unsigned AMP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [ACC_W-1:0]        freq_i,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o,
    output logic                    valid_o
);
    localparam int unsigned LANES = 2;
    localparam int unsigned QA_W  = PH_W - 2;
    localparam int unsigned MAG_W = AMP_W - 1;
    localparam logic [PH_W-1:0] QUARTER = PH_W'(1 << QA_W);

    logic [ACC_W-1:0]             acc_q;
    logic [PH_W-1:0]              phase;
    logic [LANES-1:0][QA_W-1:0]   addr;
    logic [LANES-1:0]             neg;
    logic [LANES-1:0]             neg_q;
    logic [LANES-1:0][MAG_W-1:0]  mag;
    logic [LANES-1:0][AMP_W-1:0]  smp;
    logic                         valid_q;

    qlo_phase_acc #(.ACC_W(ACC_W)) i_acc (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .freq_i(freq_i), .acc_o(acc_q)
    );

    assign phase = acc_q[ACC_W-1 -: PH_W];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PH_W-1:0] lane_ph;
        assign lane_ph = phase + (g == 0 ? '0 : QUARTER);

        qlo_fold #(.PH_W(PH_W)) i_fold (
            .phase_i(lane_ph), .addr_o(addr[g]), .neg_o(neg[g])
        );

        // Carry the sign flag alongside the table read
        always_ff @(posedge clk) begin
            if (!rst_n)    neg_q[g] <= 1'b0;
            else if (en_i) neg_q[g] <= neg[g];
        end

        assign smp[g] = neg_q[g] ? -{1'b0, mag[g]} : {1'b0, mag[g]};
    end

    qlo_quarter_rom #(.PH_W(PH_W), .AMP_W(AMP_W), .LANES(LANES)) i_rom (
        .clk(clk), .rst_n(rst_n), .rd_en_i(en_i), .addr_i(addr), .mag_o(mag)
    );

    // Valid marks the edge on which a sample was taken
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= en_i;
    end

    assign sin_o   = smp[0];
    assign cos_o   = smp[1];
    assign valid_o = valid_q;
endmodule

// File: rtl/quad_lo_synth_chk.sv
// Checker for quad_lo_synth: timing of valid, hold on idle edges,
// accumulator stepping, amplitude bound and quadrature magnitude.
module quad_lo_synth_chk #(
    parameter int unsigned ACC_W = 28,
    parameter int unsigned AMP_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en_i,
    input logic [ACC_W-1:0]        freq_i,
    input logic [ACC_W-1:0]        acc_q,
    input logic signed [AMP_W-1:0] sin_o,
    input logic signed [AMP_W-1:0] cos_o,
    input logic                    valid_o
);
    localparam int PEAK = (1 << (AMP_W - 1)) - 1;
    localparam int MOST_NEG = -(1 << (AMP_W - 1));

    int pwr;
    assign pwr = int'(sin_o) * int'(sin_o) + int'(cos_o) * int'(cos_o);

    p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> valid_o);
    p_valid_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !valid_o);
    p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(sin_o) && $stable(cos_o)));
    p_hold_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(acc_q));
    p_acc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> acc_q == ACC_W'($past(acc_q) + $past(freq_i)));
    p_amp_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (sin_o != AMP_W'(MOST_NEG) && cos_o != AMP_W'(MOST_NEG)));
    p_quadrature_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (pwr > PEAK * PEAK - 4 * PEAK && pwr < PEAK * PEAK + 4 * PEAK));
endmodule

bind quad_lo_synth quad_lo_synth_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .freq_i(freq_i), .acc_q(acc_q),
    .sin_o(sin_o), .cos_o(cos_o), .valid_o(valid_o)
);

// File: tb/test_quad_lo_synth.sv
// Bench: behavioural phase/sample model compared on every clock.
module test_quad_lo_synth;
    localparam int ACC_W = 28;
    localparam longint MODV = 64'd1 << ACC_W;
    localparam real TPI = 6.283185307179586;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [ACC_W-1:0] freq = '0;
    logic signed [11:0] sin_o, cos_o;
    logic valid_o;

    int n_run = 0;
    int n_fail = 0;
    longint acc_m = 0;
    int exp_s = 0, exp_c = 0, exp_v = 0;

    always #2.5 clk = ~clk;

    quad_lo_synth i_quad_lo_synth (
        .clk(clk), .rst_n(rst_n), .en_i(en), .freq_i(freq),
        .sin_o(sin_o), .cos_o(cos_o), .valid_o(valid_o)
    );

    function automatic int rnd(real x);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    task automatic check(string req, int act, int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    // One clock: drive, update the model, compare after the edge
    task automatic step(bit e, longint f, string req);
        @(negedge clk);
        en = e;
        freq = ACC_W'(f);
        @(posedge clk);
        if (e) begin
            longint p;
            p = acc_m >> (ACC_W - 10);
            exp_s = rnd(2047.0 * $sin(TPI * (real'(p) + 0.5) / 1024.0));
            exp_c = rnd(2047.0 * $cos(TPI * (real'(p) + 0.5) / 1024.0));
            exp_v = 1;
            acc_m = (acc_m + f) % MODV;
        end else begin
            exp_v = 0;
        end
        #1;
        check({req, " sin R4"}, int'(sin_o), exp_s);
        check({req, " cos R5"}, int'(cos_o), exp_c);
        check({req, " valid R6"}, int'(valid_o), exp_v);
    endtask

    initial begin
        #(5 * 150000);
        n_fail++;
        $display("FAIL watchdog R6 actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset sin", int'(sin_o), 0);
        check("R1 reset cos", int'(cos_o), 0);
        check("R1 reset valid", int'(valid_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release valid", int'(valid_o), 0);
        // R1: first enabled sample at index 0, zero increment holds it
        step(1, 0, "R1 idx0");
        step(1, 0, "R1 idx0 again");
        // R2/R4/R5/R8: full sweep over every index
        for (int i = 0; i < 1030; i++) step(1, 64'd1 << 18, "R8 sweep");
        // R3: half-step increment, low bits truncated
        for (int i = 0; i < 40; i++) step(1, (64'd1 << 17) + 1, "R3 trunc");
        // R2: backward stepping through the wrap
        for (int i = 0; i < 600; i++) step(1, MODV - (64'd1 << 18), "R2 wrap");
        // R7: enable gaps hold state, then resume from held phase
        for (int i = 0; i < 60; i++) step(i % 3 == 0, 64'd7 * (64'd1 << 18) + 12345, "R7 gaps");
        for (int i = 0; i < 5; i++) step(0, 64'h123_4567, "R7 idle");
        for (int i = 0; i < 200; i++) step(1, 64'd37 * (64'd1 << 18) + 999, "R5 fast");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule